// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block produces the periodic interrupt that drives an operating system tick. A 16-bit counter counts down once per tick of a counting clock. When a tick arrives while the counter already shows zero, the counter takes its reload value from a buffer register and raises an interrupt-pending flag. A buffer value of B therefore gives a period of B+1 ticks. The counting clock comes from one of two sources. The first is the peripheral clock, divided by an 8-bit prescaler followed by a selectable power-of-two post-divider. The second is an external tick input, which passes through a synchronizer and counts once per rising edge.

Software first writes the count buffer and the compare buffer. It then holds the manual-update control bit high, which copies both buffers into the active registers without counting. Finally it clears manual update in the same write that sets start. With auto-reload set, the timer runs periodically. With auto-reload clear, it fires once, stops at zero and clears its own start bit. The live count can always be observed. The pending flag stays set until software acknowledges it by writing one to it.

Top module: `tick_timer`

## Requirements
- R1: After reset, `count_o` is 0, `irq_pend_o` is 0 and every register reads back 0, so the timer is stopped.
- R2: With auto-reload set, the counter decrements by one per tick. A tick arriving while the count is 0 reloads the count buffer value B. The interval between successive underflows is (B+1) ticks.
- R3: While the manual-update bit (control bit 1) is 1, the counter is loaded from the count buffer and the active compare register is loaded from the compare buffer every cycle, and no counting takes place.
- R4: The counter moves only while start (control bit 0) is 1 and manual update is 0. Otherwise it holds its value.
- R5: With the source select (config bit 10) at 0, one tick occurs every (P+1)·2^(S+1) clock cycles. P is config bits 7:0 and S is config bits 9:8. For example, P=2 and S=0 give a divide of 6.
- R6: With config bit 10 at 1, the counter advances once per rising edge of `ext_tick_i` (after a 2-flop synchronizer) and ignores the peripheral clock divider.
- R7: `count_o` and read address 4 always show the live counter value. Read address 5 shows the active compare value.
- R8: Every underflow sets `irq_pend_o` in the following cycle.
- R9: `irq_pend_o` stays set until a write to address 6 with bit 0 at 1 clears it. If an underflow occurs in the same cycle as the clear, the flag stays set.
- R10: A write to the count buffer (address 2) while the timer runs leaves the current period unchanged and takes effect at the next reload.
- R11: With auto-reload (control bit 2) at 0, the first underflow raises the pending flag once, leaves the counter at 0 and clears the start bit.
- R12: Writes place the registers at addresses 0 (control), 1 (config), 2 (count buffer), 3 (compare buffer) and 6 (pending acknowledge). Read data appears on `rd_data_o` one cycle after `rd_addr_i` is presented. Address 6 reads the pending flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_tick_i | input | 1 | External tick clock, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Registered read data |
| count_o | output | 16 | Live counter value |
| irq_pend_o | output | 1 | Interrupt pending flag |

## Verification
The bound checker checks the following on every cycle:
- the per-tick behaviour: a decrement by exactly one, a reload from the buffer at zero, and a hold at zero in one-shot mode;
- the manual-update load and the freeze of the count while stopped;
- the pending flag's set, hold and clear rules, including set-over-clear priority;
- the clearing of start after a one-shot underflow.

Some properties span many ticks, and only the directed scenarios can show them. These are the absolute divide ratio of the prescaler and post-divider, the resulting underflow period in clock cycles, the deferred effect of a buffer rewrite on the following period, the edge counting of the external input, and the register read-back layout.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_CFG    = 3'd1,
    RA_CNTBUF = 3'd2,
    RA_CMPBUF = 3'd3,
    RA_COUNT  = 3'd4,
    RA_CMPACT = 3'd5,
    RA_PEND   = 3'd6
  } reg_addr_e;

  // control register, bit 0 start, bit 1 manual update, bit 2 auto-reload
  typedef struct packed {
    logic auto_rl;
    logic manual;
    logic start;
  } ctrl_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PSC_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = 1 << SEL_W;

  logic [PSC_W-1:0] psc_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic [DIV_W:0]   div_pow;
  logic             pre_tick;

  always_comb begin
    div_pow  = (DIV_W+1)'(1) << (int'(sel_i) + 1);
    div_lim  = DIV_W'(div_pow - 1'b1);
    pre_tick = run_i && (psc_cnt >= psc_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      psc_cnt <= '0;
      div_cnt <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (pre_tick) begin
        psc_cnt <= '0;
        if (div_cnt >= div_lim) begin
          div_cnt <= '0;
          tick_o  <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else begin
        psc_cnt <= psc_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain[0] <= 1'b0;
    else       chain[0] <= async_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (rst_i) chain[g] <= 1'b0;
        else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      last_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      last_q <= chain[STAGES-1];
      rise_o <= chain[STAGES-1] && !last_q;
    end
  end

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             manual_i,
  input  logic             auto_rl_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             uf_o,
  output logic             stop_o
);
  logic at_zero;
  logic step;

  always_comb begin
    at_zero = (cnt_o == '0);
    step    = run_i && tick_i && !manual_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o  <= '0;
      cmp_o  <= '0;
      uf_o   <= 1'b0;
      stop_o <= 1'b0;
    end else begin
      uf_o   <= 1'b0;
      stop_o <= 1'b0;
      if (manual_i) begin
        cnt_o <= cnt_buf_i;
        cmp_o <= cmp_buf_i;
      end else if (step) begin
        if (at_zero) begin
          uf_o <= 1'b1;
          if (auto_rl_i) begin
            cnt_o <= cnt_buf_i;
            cmp_o <= cmp_buf_i;
          end else begin
            stop_o <= 1'b1;
          end
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ext_tick_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_pend_o
);
  localparam int CFG_W   = PSC_W + SEL_W + 1;
  localparam int SRC_BIT = PSC_W + SEL_W;

  ctrl_t            ctrl_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_buf_q;
  logic [CNT_W-1:0] cmp_buf_q;
  logic [CNT_W-1:0] cmp_act;
  logic             run;
  logic             manual_w;
  logic             auto_w;
  logic             src_ext;
  logic             psc_tick;
  logic             ext_rise;
  logic             tick;
  logic             uf;
  logic             stop;
  logic             ack_clr;

  always_comb begin
    manual_w = ctrl_q.manual;
    auto_w   = ctrl_q.auto_rl;
    run      = ctrl_q.start && !ctrl_q.manual;
    src_ext  = cfg_q[SRC_BIT];
    tick     = src_ext ? ext_rise : psc_tick;
    ack_clr  = wr_en_i && (wr_addr_i == RA_PEND) && wr_data_i[0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q    <= '0;
      cfg_q     <= '0;
      cnt_buf_q <= '0;
      cmp_buf_q <= '0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          RA_CTRL:   ctrl_q    <= ctrl_t'(wr_data_i[2:0]);
          RA_CFG:    cfg_q     <= wr_data_i[CFG_W-1:0];
          RA_CNTBUF: cnt_buf_q <= wr_data_i[CNT_W-1:0];
          RA_CMPBUF: cmp_buf_q <= wr_data_i[CNT_W-1:0];
          default: ;
        endcase
      end
      if (stop) ctrl_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        irq_pend_o <= 1'b0;
    else if (uf)      irq_pend_o <= 1'b1;
    else if (ack_clr) irq_pend_o <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_data_o <= '0;
    end else begin
      case (rd_addr_i)
        RA_CTRL:   rd_data_o <= DATA_W'(ctrl_q);
        RA_CFG:    rd_data_o <= DATA_W'(cfg_q);
        RA_CNTBUF: rd_data_o <= DATA_W'(cnt_buf_q);
        RA_CMPBUF: rd_data_o <= DATA_W'(cmp_buf_q);
        RA_COUNT:  rd_data_o <= DATA_W'(count_o);
        RA_CMPACT: rd_data_o <= DATA_W'(cmp_act);
        RA_PEND:   rd_data_o <= DATA_W'(irq_pend_o);
        default:   rd_data_o <= '0;
      endcase
    end
  end

  tt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (run),
    .psc_i  (cfg_q[PSC_W-1:0]),
    .sel_i  (cfg_q[PSC_W+SEL_W-1:PSC_W]),
    .tick_o (psc_tick)
  );

  tt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (ext_tick_i),
    .rise_o  (ext_rise)
  );

  tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_i     (run),
    .tick_i    (tick),
    .manual_i  (manual_w),
    .auto_rl_i (auto_w),
    .cnt_buf_i (cnt_buf_q),
    .cmp_buf_i (cmp_buf_q),
    .cnt_o     (count_o),
    .cmp_o     (cmp_act),
    .uf_o      (uf),
    .stop_o    (stop)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             tick,
  input logic             manual,
  input logic             auto_rl,
  input logic [CNT_W-1:0] cnt_buf,
  input logic [CNT_W-1:0] count,
  input logic             uf,
  input logic             stop,
  input logic             ack_clr,
  input logic             pend
);

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !manual && count != '0) |=> (count + 1'b1) == $past(count));

  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !manual && count == '0 && auto_rl) |=> count == $past(cnt_buf));

  a_r3_manual_load: assert property (@(posedge clk) disable iff (rst)
    manual |=> count == $past(cnt_buf));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !manual) |=> $stable(count));

  a_r8_pend_set: assert property (@(posedge clk) disable iff (rst)
    uf |=> pend);

  a_r9_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack_clr) |=> pend);

  a_r9_pend_clear: assert property (@(posedge clk) disable iff (rst)
    (ack_clr && !uf) |=> !pend);

  a_r11_oneshot_zero: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !manual && count == '0 && !auto_rl) |=> (count == '0 && stop));

  a_r11_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop |=> !run);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .run     (run),
  .tick    (tick),
  .manual  (manual_w),
  .auto_rl (auto_w),
  .cnt_buf (cnt_buf_q),
  .count   (count_o),
  .uf      (uf),
  .stop    (stop),
  .ack_clr (ack_clr),
  .pend    (irq_pend_o)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] count;
  logic        pend;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer u0 (
    .clk_i      (clk),
    .rst_i      (rst),
    .ext_tick_i (ext),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .count_o    (count),
    .irq_pend_o (pend)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pend(output int t);
    int k;
    k = 0;
    while (!pend && k < 5000) begin @(negedge clk); k++; end
    t = cyc;
    if (!pend) check(1'b0, "pending timeout", 0, 1);
  endtask

  task automatic quiesce();
    wr(3'd0, 16'h0);
    wr(3'd6, 16'h1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check(count == 16'h0, "R1 count", count, 0);
    check(pend == 1'b0, "R1 pending", pend, 0);
    rd(3'd0, v); check(v == 16'h0, "R1 ctrl", v, 0);
    rd(3'd1, v); check(v == 16'h0, "R1 cfg", v, 0);
  endtask

  task automatic t_manual();
    logic [15:0] v;
    wr(3'd2, 16'h1234);
    wr(3'd3, 16'h0055);
    wr(3'd0, 16'h0002);
    idle(2);
    check(count == 16'h1234, "R3 manual load", count, 16'h1234);
    rd(3'd5, v); check(v == 16'h0055, "R3 compare active", v, 16'h55);
    rd(3'd4, v); check(v == 16'h1234, "R7 count readback", v, 16'h1234);
    rd(3'd3, v); check(v == 16'h0055, "R12 cmp buffer readback", v, 16'h55);
    wr(3'd0, 16'h0003);
    idle(30);
    check(count == 16'h1234, "R4 manual blocks counting", count, 16'h1234);
    wr(3'd0, 16'h0000);
    idle(30);
    check(count == 16'h1234, "R4 stopped holds", count, 16'h1234);
  endtask

  task automatic run_period(input logic [15:0] cfg, input logic [15:0] buf_v, input int exp_cyc, input string req);
    int t1, t2;
    logic [15:0] v;
    quiesce();
    wr(3'd1, cfg);
    wr(3'd2, buf_v);
    wr(3'd0, 16'h0002);
    wr(3'd0, 16'h0005);
    wait_pend(t1);
    check(pend == 1'b1, "R8 pending raised", pend, 1);
    wr(3'd6, 16'h0001);
    check(pend == 1'b0, "R9 acknowledge clears", pend, 0);
    rd(3'd6, v); check(v == 16'h0, "R12 pend readback", v, 0);
    wait_pend(t2);
    check(t2 - t1 == exp_cyc, req, t2 - t1, exp_cyc);
    idle(3);
    check(pend == 1'b1, "R9 pending holds", pend, 1);
    quiesce();
  endtask

  task automatic t_period();
    run_period(16'h0002, 16'd4, 30, "R5 R2 period div6 buf4");
    run_period(16'h0100, 16'd9, 40, "R5 R2 period div4 buf9");
    run_period(16'h0301, 16'd1, 64, "R5 R2 period div32 buf1");
  endtask

  task automatic pulse();
    ext = 1'b1; idle(3);
    ext = 1'b0; idle(6);
  endtask

  task automatic t_ext();
    quiesce();
    wr(3'd1, 16'h0400);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0002);
    wr(3'd0, 16'h0005);
    idle(40);
    check(count == 16'd3, "R6 ignores pclk divider", count, 3);
    pulse();
    check(count == 16'd2, "R6 one step per edge", count, 2);
    pulse(); pulse();
    check(count == 16'd0 && !pend, "R6 reach zero without pending", count, 0);
    pulse();
    check(count == 16'd3, "R2 reload after zero", count, 3);
    check(pend == 1'b1, "R8 pending on ext underflow", pend, 1);
    quiesce();
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_buf_update();
    int t1, t2, t3;
    quiesce();
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'd7);
    wr(3'd0, 16'h0002);
    wr(3'd0, 16'h0005);
    wait_pend(t1);
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'd19);
    wait_pend(t2);
    check(t2 - t1 == 16, "R10 current period unchanged", t2 - t1, 16);
    wr(3'd6, 16'h0001);
    wait_pend(t3);
    check(t3 - t2 == 40, "R10 new value at next reload", t3 - t2, 40);
    quiesce();
  endtask

  task automatic t_oneshot();
    int t1;
    logic [15:0] v;
    quiesce();
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0002);
    wr(3'd0, 16'h0001);
    wait_pend(t1);
    wr(3'd6, 16'h0001);
    idle(100);
    check(pend == 1'b0, "R11 single pending", pend, 0);
    check(count == 16'h0, "R11 stays at zero", count, 0);
    rd(3'd0, v); check(v == 16'h0, "R11 start cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_manual();
    t_period();
    t_ext();
    t_buf_update();
    t_oneshot();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule